// File: doc/BRIEF.md
# Five-Stage Integer Pipeline with Exposed Load Delay

This block is a small in-order integer pipeline. Each clock cycle it takes at most one pre-decoded operation from an input stream. An operation is an ALU operation, a register move or a word load. Each operation passes through five stages: fetch, register read, execute, memory and writeback. The block does not model branches, stores or instruction decoding. What it does model is when a result becomes visible to younger operations, and which write wins when several operations target the same register.

ALU and move results are forwarded to the execute inputs from the two pipeline registers that follow execute, and the youngest matching producer takes priority. Load data exists only at the end of the memory stage. The operation in the slot right after a load therefore sees the register's older contents, and no stall is inserted. Two or more slots later, the loaded value is visible. All register writes retire in program order at writeback, and a commit port reports each write. A small word-addressed data memory can be filled through a preload port while the pipeline is idle.

The operation stream has a valid strobe and no ready. The pipeline never stalls, so it accepts every presented operation, and a cycle with valid low is a bubble that still occupies one slot. The commit port also has no back-pressure: a consumer must take each commit in the cycle it is shown.

Top module: `lp_core`

## Requirements
- R1: After reset, the commit port is idle, and every register reads as zero until something writes it.
- R2: An operation accepted at a clock edge commits exactly four edges later. Commits come out in program order, one per accepted operation with a non-zero destination. A bubble commits nothing.
- R3: The operation codes behave as follows: 0 gives rs+rt, 1 gives rs-rt, 2 gives rs AND rt, 3 gives rs OR rt, 4 gives rs XOR rt, 5 gives rs plus the sign-extended immediate, 6 copies rs, and 7 loads a word from memory.
- R4: Register 0 always reads as zero. A write to register 0 is discarded and never appears on the commit port.
- R5: An ALU or move result is visible to the operation one slot later and to the operation two slots later.
- R6: The operation one slot after a load sees the register's value from before that load. If an older operation wrote that register, it sees that older value.
- R7: A loaded value is visible to any operation two or more slots after the load, whether or not a bubble sits between them.
- R8: When back-to-back operations write the same register, the later one decides the final value. This holds for load then load, and for load then move from register 0.
- R9: A load address is rs plus the sign-extended 16-bit immediate. The low 8 bits of that sum select the memory word, so addresses wrap.
- R10: A preload write stores its data at the given word, and a later load returns it.
- R11: When two in-flight producers both match a source register, the younger one supplies the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_kind | input | 3 | Operation code (see R3) |
| in_rd | input | 5 | Destination register |
| in_rs | input | 5 | First source register, also the load base |
| in_rt | input | 5 | Second source register |
| in_imm | input | 16 | Immediate, sign-extended |
| pre_we | input | 1 | Preload write strobe for the data memory |
| pre_addr | input | 8 | Preload word address |
| pre_data | input | 32 | Preload word |
| commit_valid | output | 1 | A register write retires this cycle |
| commit_idx | output | 5 | Retiring destination register |
| commit_data | output | 32 | Retiring value |

## Verification
Directed sequences put a consumer at distances one, two and three from ALU producers and from loads. This separates the execute-stage bypass, the writeback bypass and the register file's write-before-read path. A consumer placed right after a load, with an older write to the same register, shows whether the load is wrongly forwarded and whether the older value still wins. Back-to-back writes to one register, and loads with negative or wrapping addresses, check the write order and the address formation. A long random stream over eight registers then mixes every hazard distance with bubbles, and each commit is compared in value and in cycle with an in-order reference model.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_ADD  = 3'd0,
    K_SUB  = 3'd1,
    K_AND  = 3'd2,
    K_OR   = 3'd3,
    K_XOR  = 3'd4,
    K_ADDI = 3'd5,
    K_MOVE = 3'd6,
    K_LOAD = 3'd7
  } op_kind_e;
endpackage

// File: rtl/lp_regfile.sv
module lp_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  localparam int RA_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RA_W-1:0]   wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [RA_W-1:0]   ra_a,
  input  logic [RA_W-1:0]   ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  // write-before-read: a retiring write is seen by the same-cycle read
  function automatic logic [DATA_W-1:0] rd_port(input logic [RA_W-1:0] a);
    if (a == '0)                 return '0;
    else if (we && wa == a)      return wd;
    else                         return regs[a];
  endfunction

  assign rd_a = rd_port(ra_a);
  assign rd_b = rd_port(ra_b);
endmodule

// File: rtl/lp_dmem.sv
module lp_dmem #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int MA_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [MA_W-1:0]   pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic [MA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lp_bypass.sv
module lp_bypass #(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic [RA_W-1:0]   src,
  input  logic [DATA_W-1:0] read_val,
  input  logic              ex_ok,
  input  logic [RA_W-1:0]   ex_rd,
  input  logic [DATA_W-1:0] ex_val,
  input  logic              mem_ok,
  input  logic [RA_W-1:0]   mem_rd,
  input  logic [DATA_W-1:0] mem_val,
  output logic [DATA_W-1:0] opnd
);
  // younger producer (execute/memory register) wins over older one
  always_comb begin
    if (ex_ok && ex_rd == src)        opnd = ex_val;
    else if (mem_ok && mem_rd == src) opnd = mem_val;
    else                              opnd = read_val;
  end
endmodule

// File: rtl/lp_alu.sv
module lp_alu #(
  parameter int DATA_W = 32
) (
  input  lp_pkg::op_kind_e  kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm_ext,
  output logic [DATA_W-1:0] res
);
  import lp_pkg::*;

  always_comb begin
    unique case (kind)
      K_ADD:  res = a + b;
      K_SUB:  res = a - b;
      K_AND:  res = a & b;
      K_OR:   res = a | b;
      K_XOR:  res = a ^ b;
      K_MOVE: res = a;
      default: res = a + imm_ext; // immediate add and load address
    endcase
  end
endmodule

// File: rtl/lp_core.sv
module lp_core #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int NREGS     = 32,
  parameter int MEM_WORDS = 256,
  localparam int RA_W     = $clog2(NREGS),
  localparam int MA_W     = $clog2(MEM_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [lp_pkg::KIND_W-1:0] in_kind,
  input  logic [RA_W-1:0]           in_rd,
  input  logic [RA_W-1:0]           in_rs,
  input  logic [RA_W-1:0]           in_rt,
  input  logic [IMM_W-1:0]          in_imm,
  input  logic                      pre_we,
  input  logic [MA_W-1:0]           pre_addr,
  input  logic [DATA_W-1:0]         pre_data,
  output logic                      commit_valid,
  output logic [RA_W-1:0]           commit_idx,
  output logic [DATA_W-1:0]         commit_data
);
  import lp_pkg::*;

  typedef struct packed {
    logic             vld;
    logic             wr;
    op_kind_e         kind;
    logic [RA_W-1:0]  rd;
    logic [RA_W-1:0]  rs;
    logic [RA_W-1:0]  rt;
    logic [IMM_W-1:0] imm;
  } op_t;

  localparam op_t OP_IDLE = '{vld: 1'b0, wr: 1'b0, kind: K_ADD,
                              rd: '0, rs: '0, rt: '0, imm: '0};

  // stage registers: fetch/read, read/execute, execute/memory, memory/writeback
  op_t               s_if, s_rd, s_ex, s_mem;
  logic [DATA_W-1:0] rd_val [2];
  logic [DATA_W-1:0] ex_res, mem_res;

  // register file read (during the read stage) and writeback
  logic [DATA_W-1:0] rf_dat_a, rf_dat_b;
  logic [RA_W-1:0]   rf_ra_a;
  assign rf_ra_a = s_if.rs;

  lp_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(s_mem.vld && s_mem.wr), .wa(s_mem.rd), .wd(mem_res),
    .ra_a(rf_ra_a), .ra_b(s_if.rt),
    .rd_a(rf_dat_a), .rd_b(rf_dat_b)
  );

  // execute-stage operand bypass; loads in the memory stage are not yet resolved
  logic              ex_fwd_ok, mem_fwd_ok;
  logic [RA_W-1:0]   srcs [2];
  logic [DATA_W-1:0] opnd [2];

  assign ex_fwd_ok  = s_ex.vld && s_ex.wr && (s_ex.kind != K_LOAD);
  assign mem_fwd_ok = s_mem.vld && s_mem.wr;
  assign srcs[0]    = s_rd.rs;
  assign srcs[1]    = s_rd.rt;

  for (genvar g = 0; g < 2; g++) begin : g_byp
    lp_bypass #(.DATA_W(DATA_W), .RA_W(RA_W)) u_byp (
      .src(srcs[g]), .read_val(rd_val[g]),
      .ex_ok(ex_fwd_ok), .ex_rd(s_ex.rd), .ex_val(ex_res),
      .mem_ok(mem_fwd_ok), .mem_rd(s_mem.rd), .mem_val(mem_res),
      .opnd(opnd[g])
    );
  end

  logic [DATA_W-1:0] imm_ext, alu_out;
  assign imm_ext = {{(DATA_W-IMM_W){s_rd.imm[IMM_W-1]}}, s_rd.imm};

  lp_alu #(.DATA_W(DATA_W)) u_alu (
    .kind(s_rd.kind), .a(opnd[0]), .b(opnd[1]),
    .imm_ext(imm_ext), .res(alu_out)
  );

  // memory stage: word select from the low address bits
  logic [DATA_W-1:0] ld_data;
  lp_dmem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .rd_addr(ex_res[MA_W-1:0]), .rd_data(ld_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_if   <= OP_IDLE;
      s_rd   <= OP_IDLE;
      s_ex   <= OP_IDLE;
      s_mem  <= OP_IDLE;
      rd_val <= '{default: '0};
      ex_res <= '0;
      mem_res <= '0;
    end else begin
      s_if.vld  <= in_valid;
      s_if.wr   <= in_valid && (in_rd != '0);
      s_if.kind <= op_kind_e'(in_kind);
      s_if.rd   <= in_rd;
      s_if.rs   <= in_rs;
      s_if.rt   <= in_rt;
      s_if.imm  <= in_imm;

      s_rd      <= s_if;
      rd_val[0] <= rf_dat_a;
      rd_val[1] <= rf_dat_b;

      s_ex      <= s_rd;
      ex_res    <= alu_out;

      s_mem     <= s_ex;
      mem_res   <= (s_ex.kind == K_LOAD) ? ld_data : ex_res;
    end
  end

  assign commit_valid = s_mem.vld && s_mem.wr;
  assign commit_idx   = s_mem.rd;
  assign commit_data  = mem_res;
endmodule

// File: rtl/lp_core_chk.sv
module lp_core_chk #(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [RA_W-1:0]   in_rd,
  input logic              commit_valid,
  input logic [RA_W-1:0]   commit_idx,
  input logic [RA_W-1:0]   rf_ra,
  input logic [DATA_W-1:0] rf_rd
);
  // cycles since reset, saturating, so history checks never reach before reset
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_commit_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && since_rst == 3'd4) |->
      ($past(in_valid, 4) && commit_idx == $past(in_rd, 4)));

  assert_bubble_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && !$past(in_valid, 4)) |-> !commit_valid);

  assert_early_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 3'd4) |-> !commit_valid);

  assert_no_zero_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_idx != '0);

  assert_zero_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ra == '0) |-> rf_rd == '0);
endmodule

bind lp_core lp_core_chk #(.DATA_W(DATA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
  .commit_valid(commit_valid), .commit_idx(commit_idx),
  .rf_ra(rf_ra_a), .rf_rd(rf_dat_a)
);

// File: tb/lp_core_tb.sv
module lp_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [4:0]  in_rd = '0, in_rs = '0, in_rt = '0;
  logic [15:0] in_imm = '0;
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic        commit_valid;
  logic [4:0]  commit_idx;
  logic [31:0] commit_data;

  lp_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_data(commit_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] arch [32];
  logic [31:0] mem_m [256];
  bit          last_load = 1'b0;
  logic [4:0]  last_rd = '0;
  logic [31:0] last_old = '0;

  logic [4:0]  q_idx [$];
  logic [31:0] q_dat [$];
  int          q_cyc [$];
  string       q_tag [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > MAX_CYC) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, MAX_CYC);
      finish_run();
    end
  end

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] rd_model(input logic [4:0] r);
    if (r == 0) return 32'd0;
    if (last_load && last_rd == r) return last_old; // load delay slot
    return arch[r];
  endfunction

  function automatic logic [31:0] exec_model(input logic [2:0] k, input logic [31:0] a,
                                             input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] s;
    s = a + sext(imm);
    case (k)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return s;
      3'd6: return a;
      default: return mem_m[s[7:0]];
    endcase
  endfunction

  task automatic issue(input logic [2:0] k, input logic [4:0] rd, input logic [4:0] rs,
                       input logic [4:0] rt, input logic [15:0] imm, input string tag);
    logic [31:0] res;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_rd = rd; in_rs = rs; in_rt = rt; in_imm = imm;
    res = exec_model(k, rd_model(rs), rd_model(rt), imm);
    last_load = (k == 3'd7) && (rd != 0);
    last_rd   = rd;
    last_old  = arch[rd];
    if (rd != 0) begin
      arch[rd] = res;
      q_idx.push_back(rd); q_dat.push_back(res);
      q_cyc.push_back(cyc + 4); q_tag.push_back(tag);
    end
  endtask

  task automatic bubble();
    @(negedge clk);
    in_valid = 1'b0;
    last_load = 1'b0;
  endtask

  task automatic preload(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    mem_m[a] = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // commit monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (commit_valid) begin
        checks++;
        if (q_idx.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected commit: actual r%0d=%h expected none", commit_idx, commit_data);
        end else begin
          if (commit_idx !== q_idx[0] || commit_data !== q_dat[0] || cyc != q_cyc[0]) begin
            errors++;
            $display("FAIL %s commit: actual r%0d=%h @%0d expected r%0d=%h @%0d", q_tag[0],
                     commit_idx, commit_data, cyc, q_idx[0], q_dat[0], q_cyc[0]);
          end
          void'(q_idx.pop_front()); void'(q_dat.pop_front());
          void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_idx.size() != 0 && q_cyc[0] <= cyc) begin
        checks++; errors++;
        $display("FAIL %s missing commit: actual none expected r%0d=%h @%0d",
                 q_tag[0], q_idx[0], q_dat[0], q_cyc[0]);
        void'(q_idx.pop_front()); void'(q_dat.pop_front());
        void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) arch[i] = 32'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checks++;
      if (commit_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle after reset: actual %b expected 0", commit_valid);
      end
    end

    // R10: preload every word with a computed pattern
    for (int a = 0; a < 256; a++) preload(a[7:0], (a * 32'h0101_0101) ^ 32'h5A00_00A5);
    preload(8'd10, 32'h0000_AAAA);
    preload(8'd11, 32'h0000_BBBB);

    issue(3'd6, 5'd1, 5'd3, 5'd0, 16'd0, "R1");        // untouched register reads zero
    issue(3'd5, 5'd1, 5'd0, 5'd0, 16'd5, "R3");        // r1 = 5
    issue(3'd5, 5'd2, 5'd1, 5'd0, 16'd3, "R5");        // distance one: 8
    issue(3'd0, 5'd3, 5'd1, 5'd2, 16'd0, "R5");        // distances two and one: 13
    issue(3'd1, 5'd4, 5'd3, 5'd1, 16'd0, "R3");
    issue(3'd2, 5'd5, 5'd3, 5'd2, 16'd0, "R3");
    issue(3'd3, 5'd6, 5'd3, 5'd2, 16'd0, "R3");
    issue(3'd4, 5'd7, 5'd3, 5'd1, 16'd0, "R3");
    issue(3'd5, 5'd0, 5'd1, 5'd0, 16'd9, "R4");        // discarded, no commit
    issue(3'd6, 5'd8, 5'd0, 5'd0, 16'd0, "R4");        // zero source
    issue(3'd5, 5'd4, 5'd0, 5'd0, 16'd10, "R9");       // base 10
    issue(3'd7, 5'd5, 5'd4, 5'd0, 16'd0, "R10");       // load 0xAAAA
    issue(3'd6, 5'd6, 5'd5, 5'd0, 16'd0, "R6");        // old r5
    issue(3'd6, 5'd7, 5'd5, 5'd0, 16'd0, "R7");        // loaded value
    issue(3'd7, 5'd5, 5'd4, 5'd0, 16'd1, "R8");        // load 0xBBBB
    issue(3'd7, 5'd5, 5'd4, 5'd0, 16'd0, "R8");        // load 0xAAAA, later wins
    issue(3'd6, 5'd8, 5'd5, 5'd0, 16'd0, "R6");        // sees 0xBBBB
    issue(3'd6, 5'd9, 5'd5, 5'd0, 16'd0, "R8");        // sees 0xAAAA
    issue(3'd7, 5'd5, 5'd4, 5'd0, 16'd1, "R8");
    issue(3'd6, 5'd5, 5'd0, 5'd0, 16'd0, "R8");        // move from zero wins
    issue(3'd6, 5'd10, 5'd5, 5'd0, 16'd0, "R8");       // zero
    issue(3'd7, 5'd11, 5'd4, 5'd0, 16'hFFFE, "R9");    // address 8
    issue(3'd5, 5'd12, 5'd0, 5'd0, 16'h01F5, "R9");
    issue(3'd7, 5'd13, 5'd12, 5'd0, 16'd0, "R9");      // wraps to word 0xF5
    issue(3'd5, 5'd1, 5'd0, 5'd0, 16'd1, "R11");
    issue(3'd5, 5'd1, 5'd0, 5'd0, 16'd2, "R11");
    issue(3'd0, 5'd2, 5'd1, 5'd1, 16'd0, "R11");       // 4: youngest wins
    issue(3'd5, 5'd14, 5'd0, 5'd0, 16'd7, "R6");
    issue(3'd7, 5'd14, 5'd4, 5'd0, 16'd0, "R6");
    issue(3'd6, 5'd15, 5'd14, 5'd0, 16'd0, "R6");      // 7 from the older writer
    issue(3'd7, 5'd16, 5'd4, 5'd0, 16'd1, "R7");
    bubble();
    issue(3'd6, 5'd17, 5'd16, 5'd0, 16'd0, "R7");      // across a bubble
    bubble();

    // random stream with dense hazards over r0..r7
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 100) < 85) begin
        logic [2:0] k;
        k = 3'($urandom % 8);
        issue(k, 5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8),
              16'($signed(($urandom % 24)) - 8), "R2");
      end else begin
        bubble();
      end
    end
    bubble();
    repeat (8) @(negedge clk);

    checks++;
    if (q_idx.size() != 0) begin
      errors++;
      $display("FAIL R2 drain: actual %0d pending expected 0", q_idx.size());
    end
    finish_run();
  end
endmodule